// File: doc/BRIEF.md
# Serial Controller Card Bus Glue with Vector-Fetch Chain

This block is the bus-side logic of one expansion card that carries two dual-channel serial controllers on an 8-bit I/O bus. It turns host reads and writes in the card's eight-port window into a chip select per controller, plus a channel line and a control/data line. Several cards can be chained. A host write to a shared acknowledge port arms an interrupt-acknowledge latch on every card at once. A later read of that port takes the interrupt vector from the one card where the controllers' enable chain breaks, and that read disarms the latch again.

Interrupt requests are gathered along the chain. The card whose incoming chain connector is left open finds that input pulled high and becomes master. Only the master raises the host interrupt. Slaves pull down a shared active-low request line that runs through the chain cable. A card fitted with only one controller routes the chain past the empty socket.

Top module: `scc_bus_glue`

## Requirements
- R1: With AEN low, the card answers in an 8-port window starting at 0x150 when `base_strap` is 0, or at 0x158 when it is 1. A read there drives `dbus_oe` high and `dbus_out` equals `ctrl_rdata`.
- R2: Inside the window, address bit 2 selects the controller: 0 gives `ctrl_cs_n`=2'b10 and 1 gives 2'b01. A select is only given while `ior_n` or `iow_n` is low. `ctrl_chan_b` follows address bit 1, and `ctrl_reg_data` follows bit 0 (0 = control, 1 = data). Writes never drive `dbus_oe`.
- R3: While AEN is high, no select is given, `dbus_oe` stays low, and a write to 0x168 does not arm the latch.
- R4: A write to 0x168 arms the acknowledge latch at the next clock edge, and `intack_n` goes low.
- R5: After a read of 0x168, the latch clears at the first clock edge after `ior_n` has returned high. Until then `intack_n` stays low.
- R6: During a read of 0x168 with the latch armed, `dbus_oe` is high only when `chain_iei` is high and the card's effective enable-out is low. The effective enable-out is `ieo_b`, or `ieo_a` when `one_ctrl` is set. A read of 0x168 with the latch clear drives nothing.
- R7: During an armed vector read, controller 0 is selected when `chain_iei`=1 and `ieo_a`=0. Controller 1 is selected when `ieo_a`=1 and `ieo_b`=0. `iei_b` always equals `ieo_a`.
- R8: With `one_ctrl` set, controller 1 is never selected for a vector and its interrupt request is ignored.
- R9: With `chain_open` high, the card is master: `host_irq` is high when a controller requests or `chain_irq_n` is low, and `chain_irq_pull` is 0. With `chain_open` low, `host_irq` is 0 and `chain_irq_pull` reflects the card's own request.
- R10: Addresses outside the window and the acknowledge port give no select and leave `dbus_oe` low.
- R11: While reset is held, and after it, the latch is clear (`intack_n`=1), even if a write to 0x168 is seen during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 10 | I/O address |
| aen | input | 1 | DMA address enable; high blocks all decode |
| ior_n | input | 1 | I/O read strobe, active low |
| iow_n | input | 1 | I/O write strobe, active low |
| base_strap | input | 1 | Adds 8 to the card base address |
| one_ctrl | input | 1 | Only controller 0 is fitted |
| chain_open | input | 1 | Incoming chain connector is open (pulled high) |
| chain_iei | input | 1 | Enable-in of controller 0, taken from the chain |
| ieo_a | input | 1 | Enable-out of controller 0 |
| ieo_b | input | 1 | Enable-out of controller 1 |
| ctrl_rdata | input | 8 | Read data or vector from the controllers |
| ctrl_irq_n | input | 2 | Controller interrupt requests, active low |
| chain_irq_n | input | 1 | Shared active-low request line from the slaves |
| ctrl_cs_n | output | 2 | Controller chip selects, active low |
| ctrl_chan_b | output | 1 | Channel select inside a controller |
| ctrl_reg_data | output | 1 | 1 = data register, 0 = control register |
| iei_b | output | 1 | Enable-in of controller 1 |
| intack_n | output | 1 | Interrupt-acknowledge to the controllers, active low |
| dbus_out | output | 8 | Data driven onto the host bus |
| dbus_oe | output | 1 | Host data buffer enable |
| host_irq | output | 1 | Host interrupt request (master only) |
| chain_irq_pull | output | 1 | Pulls the shared request line low |
| is_master | output | 1 | Card is chain master |

## Verification
The hardest case is a vector fetch that ends at a chosen point in the chain. It needs an armed latch, a held read of 0x168, and a particular enable-in/enable-out pattern, and it must be seen before the read edge disarms the latch. The bench arms the latch with one write. It then holds `ior_n` low while it steps the chain pins through four cases: break at controller 0, break at controller 1, upstream owner, and downstream owner. It also covers single-controller mode. Only after that does it release the strobe and count the edges until `intack_n` rises.

// File: rtl/scc_glue_pkg.sv
package scc_glue_pkg;
  localparam int ADDR_W     = 10;
  localparam int WIN_LOG2   = 3;
  localparam int STRAP_STEP = 1 << WIN_LOG2;
  localparam int N_CTRL     = 2;

  typedef logic [ADDR_W-1:0] io_addr_t;

  // Base of this card's window, moved up one window by the strap.
  function automatic io_addr_t card_base(input io_addr_t first, input logic strap);
    card_base = strap ? io_addr_t'(first + io_addr_t'(STRAP_STEP)) : first;
  endfunction

  // Address lies in the aligned window that starts at base.
  function automatic logic in_window(input io_addr_t a, input io_addr_t base);
    in_window = (a[ADDR_W-1:WIN_LOG2] == base[ADDR_W-1:WIN_LOG2]);
  endfunction
endpackage

// File: rtl/scc_port_dec.sv
module scc_port_dec
  import scc_glue_pkg::*;
#(
  parameter io_addr_t FIRST_BASE = 10'h150,
  parameter io_addr_t ACK_ADDR   = 10'h168
) (
  input  io_addr_t addr,
  input  logic     aen,
  input  logic     strap,
  output logic     card_hit,
  output logic     ack_hit,
  output logic     chip_sel,
  output logic     chan_b,
  output logic     reg_data
);
  io_addr_t base;

  assign base     = card_base(FIRST_BASE, strap);
  assign card_hit = !aen && in_window(addr, base);
  assign ack_hit  = !aen && (addr == ACK_ADDR);
  assign chip_sel = addr[WIN_LOG2-1];
  assign chan_b   = addr[1];
  assign reg_data = addr[0];
endmodule

// File: rtl/scc_intack_latch.sv
module scc_intack_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic vec_rd,
  input  logic ior_n,
  output logic ack_q,
  output logic clr_evt
);
  logic vec_rd_q;

  // The end of a vector read is seen as the strobe being high after a read cycle.
  assign clr_evt = vec_rd_q && ior_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q    <= 1'b0;
      vec_rd_q <= 1'b0;
    end else begin
      vec_rd_q <= vec_rd;
      if (set_req)      ack_q <= 1'b1;
      else if (clr_evt) ack_q <= 1'b0;
    end
  end

  a_r4_set_arms: assert property (@(posedge clk) disable iff (!rst_n)
    set_req |=> ack_q);
  a_r5_read_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !set_req) |=> !ack_q);
endmodule

// File: rtl/scc_irq_route.sv
module scc_irq_route (
  input  logic [1:0] irq_n,
  input  logic       one_ctrl,
  input  logic       chain_open,
  input  logic       chain_irq_n,
  output logic       is_master,
  output logic       host_irq,
  output logic       chain_pull
);
  logic own_irq;

  assign own_irq    = !irq_n[0] || (!one_ctrl && !irq_n[1]);
  assign is_master  = chain_open;
  assign host_irq   = is_master && (own_irq || !chain_irq_n);
  assign chain_pull = !is_master && own_irq;
endmodule

// File: rtl/scc_bus_glue.sv
module scc_bus_glue
  import scc_glue_pkg::*;
#(
  parameter int       DATA_W     = 8,
  parameter io_addr_t FIRST_BASE = 10'h150,
  parameter io_addr_t ACK_ADDR   = 10'h168
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              aen,
  input  logic              ior_n,
  input  logic              iow_n,
  input  logic              base_strap,
  input  logic              one_ctrl,
  input  logic              chain_open,
  input  logic              chain_iei,
  input  logic              ieo_a,
  input  logic              ieo_b,
  input  logic [DATA_W-1:0] ctrl_rdata,
  input  logic [N_CTRL-1:0] ctrl_irq_n,
  input  logic              chain_irq_n,
  output logic [N_CTRL-1:0] ctrl_cs_n,
  output logic              ctrl_chan_b,
  output logic              ctrl_reg_data,
  output logic              iei_b,
  output logic              intack_n,
  output logic [DATA_W-1:0] dbus_out,
  output logic              dbus_oe,
  output logic              host_irq,
  output logic              chain_irq_pull,
  output logic              is_master
);
  logic card_hit, ack_hit, chip_sel;
  logic ack_q, clr_evt;
  logic strobe, vec_phase, ieo_eff, card_owns_vec;
  logic [N_CTRL-1:0] vec_pick;
  logic [N_CTRL-1:0] cs;

  scc_port_dec #(.FIRST_BASE(FIRST_BASE), .ACK_ADDR(ACK_ADDR)) u_dec (
    .addr(io_addr), .aen(aen), .strap(base_strap),
    .card_hit(card_hit), .ack_hit(ack_hit), .chip_sel(chip_sel),
    .chan_b(ctrl_chan_b), .reg_data(ctrl_reg_data)
  );

  scc_intack_latch u_ack (
    .clk(clk), .rst_n(rst_n),
    .set_req(ack_hit && !iow_n),
    .vec_rd(ack_hit && !ior_n),
    .ior_n(ior_n),
    .ack_q(ack_q), .clr_evt(clr_evt)
  );

  scc_irq_route u_irq (
    .irq_n(ctrl_irq_n), .one_ctrl(one_ctrl), .chain_open(chain_open),
    .chain_irq_n(chain_irq_n), .is_master(is_master),
    .host_irq(host_irq), .chain_pull(chain_irq_pull)
  );

  assign strobe        = !ior_n || !iow_n;
  assign vec_phase     = ack_hit && !ior_n && ack_q;
  assign ieo_eff       = one_ctrl ? ieo_a : ieo_b;
  assign card_owns_vec = chain_iei && !ieo_eff;
  assign iei_b         = ieo_a;
  assign intack_n      = !ack_q;

  // The controller where the enable chain breaks supplies the vector.
  assign vec_pick[0] = chain_iei && !ieo_a;
  assign vec_pick[1] = !one_ctrl && ieo_a && !ieo_b;

  for (genvar i = 0; i < N_CTRL; i++) begin : g_cs
    assign cs[i] = (card_hit && strobe && (chip_sel == i[0])) || (vec_phase && vec_pick[i]);
  end
  assign ctrl_cs_n = ~cs;

  assign dbus_oe  = (card_hit && !ior_n) || (vec_phase && card_owns_vec);
  assign dbus_out = ctrl_rdata;

  a_r2_one_select: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~ctrl_cs_n));
  a_r3_aen_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    aen |-> (ctrl_cs_n == '1) && !dbus_oe);
  a_r6_vec_owner: assert property (@(posedge clk) disable iff (!rst_n)
    (dbus_oe && ack_hit) |-> (chain_iei && !ieo_eff && !intack_n));
  a_r9_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !is_master |-> !host_irq);
  a_r8_single_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    one_ctrl |-> ctrl_cs_n[1] || !ior_n && card_hit || !iow_n && card_hit);
endmodule

// File: tb/scc_bus_glue_bench.sv
module scc_bus_glue_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [9:0] io_addr = '0;
  logic aen = 1'b0, ior_n = 1'b1, iow_n = 1'b1, base_strap = 1'b0;
  logic one_ctrl = 1'b0, chain_open = 1'b1, chain_iei = 1'b1;
  logic ieo_a = 1'b1, ieo_b = 1'b1;
  logic [7:0] ctrl_rdata = 8'hA5;
  logic [1:0] ctrl_irq_n = 2'b11;
  logic chain_irq_n = 1'b1;
  logic [1:0] ctrl_cs_n;
  logic ctrl_chan_b, ctrl_reg_data, iei_b, intack_n, dbus_oe;
  logic host_irq, chain_irq_pull, is_master;
  logic [7:0] dbus_out;

  int n_run = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  scc_bus_glue u_scc_bus_glue (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .aen(aen), .ior_n(ior_n),
    .iow_n(iow_n), .base_strap(base_strap), .one_ctrl(one_ctrl),
    .chain_open(chain_open), .chain_iei(chain_iei), .ieo_a(ieo_a), .ieo_b(ieo_b),
    .ctrl_rdata(ctrl_rdata), .ctrl_irq_n(ctrl_irq_n), .chain_irq_n(chain_irq_n),
    .ctrl_cs_n(ctrl_cs_n), .ctrl_chan_b(ctrl_chan_b), .ctrl_reg_data(ctrl_reg_data),
    .iei_b(iei_b), .intack_n(intack_n), .dbus_out(dbus_out), .dbus_oe(dbus_oe),
    .host_irq(host_irq), .chain_irq_pull(chain_irq_pull), .is_master(is_master)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Layout: req[20:17] aen[16] ior_n[15] iow_n[14] strap[13] addr[12:3] cs_n[2:1] oe[0]
  localparam int NV = 15;
  localparam logic [20:0] VEC [NV] = '{
    {4'd1,  1'b0, 1'b0, 1'b1, 1'b0, 10'h150, 2'b10, 1'b1}, // R1 first port, ctrl 0 control
    {4'd2,  1'b0, 1'b0, 1'b1, 1'b0, 10'h151, 2'b10, 1'b1}, // R2 data register
    {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 10'h153, 2'b10, 1'b0}, // R2 write, channel b data
    {4'd2,  1'b0, 1'b0, 1'b1, 1'b0, 10'h154, 2'b01, 1'b1}, // R2 ctrl 1
    {4'd2,  1'b0, 1'b1, 1'b0, 1'b0, 10'h157, 2'b01, 1'b0}, // R2 write ctrl 1 last port
    {4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 10'h158, 2'b11, 1'b0}, // R10 just past window
    {4'd1,  1'b0, 1'b0, 1'b1, 1'b1, 10'h158, 2'b10, 1'b1}, // R1 strapped base
    {4'd1,  1'b0, 1'b0, 1'b1, 1'b1, 10'h15F, 2'b01, 1'b1}, // R1 strapped top
    {4'd1,  1'b0, 1'b0, 1'b1, 1'b1, 10'h150, 2'b11, 1'b0}, // R1 strapped card ignores low window
    {4'd3,  1'b1, 1'b0, 1'b1, 1'b0, 10'h150, 2'b11, 1'b0}, // R3 aen read
    {4'd3,  1'b1, 1'b1, 1'b0, 1'b0, 10'h154, 2'b11, 1'b0}, // R3 aen write
    {4'd2,  1'b0, 1'b1, 1'b1, 1'b0, 10'h150, 2'b11, 1'b0}, // R2 no strobe
    {4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 10'h14F, 2'b11, 1'b0}, // R10 below window
    {4'd10, 1'b0, 1'b0, 1'b1, 1'b0, 10'h160, 2'b11, 1'b0}, // R10 above window
    {4'd6,  1'b0, 1'b0, 1'b1, 1'b0, 10'h168, 2'b11, 1'b0}  // R6 vector read, latch clear
  };

  task automatic idle_bus();
    aen = 1'b0; ior_n = 1'b1; iow_n = 1'b1; io_addr = '0; base_strap = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R11: write to acknowledge port while reset is held
    @(negedge clk); io_addr = 10'h168; iow_n = 1'b0;
    @(negedge clk); #2 chk("R11 latch held clear in reset", intack_n, 1'b1);
    idle_bus();
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #2 chk("R11 after reset", {intack_n, dbus_oe, ctrl_cs_n}, {1'b1, 1'b0, 2'b11});

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      @(negedge clk);
      aen = v[16]; ior_n = v[15]; iow_n = v[14]; base_strap = v[13]; io_addr = v[12:3];
      #2;
      chk($sformatf("R%0d vector %0d", v[20:17], i),
          {ctrl_cs_n, dbus_oe, ctrl_chan_b, ctrl_reg_data, (dbus_oe ? dbus_out : 8'h00)},
          {v[2:1], v[0], v[4], v[3], (v[0] ? ctrl_rdata : 8'h00)});
    end
    idle_bus();

    // R3: write to 0x168 with aen high does not arm
    @(negedge clk); aen = 1'b1; io_addr = 10'h168; iow_n = 1'b0;
    @(negedge clk); idle_bus();
    @(negedge clk); #2 chk("R3 aen write to ack port", intack_n, 1'b1);

    // R4: arm
    @(negedge clk); io_addr = 10'h168; iow_n = 1'b0;
    @(negedge clk); idle_bus(); #2 chk("R4 latch armed", intack_n, 1'b0);

    // R6/R7: vector read with various chain states, strobe held low
    @(negedge clk); io_addr = 10'h168; ior_n = 1'b0; ctrl_rdata = 8'h3C;
    chain_iei = 1'b1; ieo_a = 1'b0; ieo_b = 1'b0;
    #2 chk("R7 ctrl 0 owns vector", {ctrl_cs_n, dbus_oe, dbus_out}, {2'b10, 1'b1, 8'h3C});
    chk("R7 iei_b follows ieo_a", iei_b, 1'b0);
    @(negedge clk); ieo_a = 1'b1; ieo_b = 1'b0;
    #2 chk("R7 ctrl 1 owns vector", {ctrl_cs_n, dbus_oe, iei_b}, {2'b01, 1'b1, 1'b1});
    @(negedge clk); chain_iei = 1'b0; ieo_a = 1'b1; ieo_b = 1'b1;
    #2 chk("R6 upstream card owns vector", {ctrl_cs_n, dbus_oe}, {2'b11, 1'b0});
    @(negedge clk); chain_iei = 1'b1; ieo_a = 1'b1; ieo_b = 1'b1;
    #2 chk("R6 downstream card owns vector", {ctrl_cs_n, dbus_oe}, {2'b11, 1'b0});
    @(negedge clk); one_ctrl = 1'b1; ieo_a = 1'b1; ieo_b = 1'b0;
    #2 chk("R8 single controller ignores ieo_b", {ctrl_cs_n, dbus_oe}, {2'b11, 1'b0});
    @(negedge clk); ieo_a = 1'b0; ieo_b = 1'b1;
    #2 chk("R8 single controller owns vector", {ctrl_cs_n, dbus_oe}, {2'b10, 1'b1});
    chk("R5 latch held during read", intack_n, 1'b0);

    // R5: strobe released, clear at next edge
    @(negedge clk); ior_n = 1'b1;
    #2 chk("R5 not cleared before edge", intack_n, 1'b0);
    @(negedge clk); idle_bus();
    #2 chk("R5 cleared after read end", intack_n, 1'b1);
    one_ctrl = 1'b0; ieo_a = 1'b1; ieo_b = 1'b1;

    // R9/R8: interrupt routing
    @(negedge clk); chain_open = 1'b1; ctrl_irq_n = 2'b11; chain_irq_n = 1'b1;
    #2 chk("R9 master idle", {is_master, host_irq, chain_irq_pull}, 3'b100);
    @(negedge clk); ctrl_irq_n = 2'b01;
    #2 chk("R9 master own request", {host_irq, chain_irq_pull}, 2'b10);
    @(negedge clk); ctrl_irq_n = 2'b11; chain_irq_n = 1'b0;
    #2 chk("R9 master slave request", host_irq, 1'b1);
    @(negedge clk); chain_open = 1'b0; chain_irq_n = 1'b1; ctrl_irq_n = 2'b10;
    #2 chk("R9 slave forwards", {is_master, host_irq, chain_irq_pull}, 3'b001);
    @(negedge clk); one_ctrl = 1'b1; ctrl_irq_n = 2'b01;
    #2 chk("R8 empty socket request ignored", chain_irq_pull, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule